// File: doc/BRIEF.md
# Port Pin Transition Flag

This block watches the most significant bit of an input port and raises a sticky flag when that pin makes a chosen transition, falling or rising. The pin is asynchronous to the block clock, so it first crosses a short flop chain. The edge is found by comparing the synchronised value against its value one clock earlier. A steady level therefore never sets the flag. Only a change in the chosen direction sets it.

Software selects the direction and enables the interrupt with a control write. The choice is carried entirely by two address lines, and no data bus is involved. The flag appears in bit 6 of a shared status byte. The timer expiry flag, which comes from a neighbouring block, occupies bit 7. A status read returns the flag and clears it on the same clock. An active-low interrupt request follows the flag while the interrupt enable is set.

A build option lets the flag come out of reset already set. This matches a device that can power up with the flag set before any read.

Top module: `port_edge_flag`

## Requirements
- R1: After synchronous reset the edge flag is 0, the interrupt enable is 0 so `irq_n` is 1, and the polarity selects falling edges. The exception is a build with `FLAG_INIT` = 1, covered by R10.
- R2: With polarity falling (control write with `ctrl_addr[0]` = 0), a 1-to-0 change of `pin_async` sets the flag, and a 0-to-1 change does not.
- R3: With polarity rising (control write with `ctrl_addr[0]` = 1), a 0-to-1 change of `pin_async` sets the flag, and a 1-to-0 change does not.
- R4: A pin held at a constant level sets nothing. Once a read has cleared the flag after an edge, the flag stays 0 for as long as the level holds.
- R5: `status_out` bit 7 equals `timer_flag_in`, bit 6 equals the edge flag, and bits 5 to 0 read 0.
- R6: A cycle with `status_rd` = 1 shows the flag value from before the clear on `status_out`. The flag is 0 after that clock unless R7 applies. Control writes leave the flag unchanged.
- R7: If a qualifying edge and a status read fall on the same clock, the flag is 1 after that clock.
- R8: `irq_n` is 0 exactly while the edge flag is 1 and the interrupt enable is 1. The enable is set by a control write with `ctrl_addr[1]` = 1 and cleared by one with `ctrl_addr[1]` = 0.
- R9: The flag becomes 1 on the (SYNC_STAGES+1)-th rising clock edge after the pin changes, and not before.
- R10: With `FLAG_INIT` = 1 the flag is 1 straight after reset, and a status read clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_async | input | 1 | Port bit 7, asynchronous to clk |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_addr | input | 2 | Bit 0 selects polarity (1 rising), bit 1 enables the interrupt |
| status_rd | input | 1 | Status register read strobe, clears the edge flag |
| timer_flag_in | input | 1 | Timer expiry flag from the timer block |
| status_out | output | 8 | Status byte: timer flag, edge flag, zeros |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds two copies of the block side by side. The first uses the defaults: a two-flop synchroniser and a flag that resets to 0. This copy carries the edge-latency count, the coincident edge-and-read case and the random polarity, enable and pin sweep. The second copy uses three synchroniser stages and `FLAG_INIT` = 1. That makes the power-up-set flag visible right after reset, along with its clearing by a read and the interrupt it raises once enabled.

// File: rtl/port_edge_flag.sv
module port_edge_flag #(
  parameter int SYNC_STAGES = 2,
  parameter bit FLAG_INIT   = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_async,
  input  logic       ctrl_wr,
  input  logic [1:0] ctrl_addr,
  input  logic       status_rd,
  input  logic       timer_flag_in,
  output logic [7:0] status_out,
  output logic       irq_n
);
  localparam int SW = SYNC_STAGES;

  logic [SW-1:0] sync_q;
  logic          prev_q;
  logic          rise_sel_q;
  logic          irq_en_q;
  logic          flag_q;
  logic          sync_o;
  logic          edge_hit;

  assign sync_o   = sync_q[SW-1];
  assign edge_hit = rise_sel_q ? (sync_o & ~prev_q) : (~sync_o & prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= (sync_q << 1) | SW'(pin_async);
      prev_q <= sync_o;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_sel_q <= 1'b0;
      irq_en_q   <= 1'b0;
    end else if (ctrl_wr) begin
      rise_sel_q <= ctrl_addr[0];
      irq_en_q   <= ctrl_addr[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            flag_q <= FLAG_INIT;
    else if (edge_hit)  flag_q <= 1'b1;
    else if (status_rd) flag_q <= 1'b0;
  end

  assign status_out = {timer_flag_in, flag_q, 6'b0};
  assign irq_n      = ~(flag_q & irq_en_q);
endmodule

// File: rtl/port_edge_flag_chk.sv
module port_edge_flag_chk (
  input logic       clk,
  input logic       rst,
  input logic       ctrl_wr,
  input logic [1:0] ctrl_addr,
  input logic       status_rd,
  input logic       timer_flag_in,
  input logic [7:0] status_out,
  input logic       irq_n,
  input logic       edge_hit,
  input logic       flag_q
);
  p_rst_irq_r1: assert property (@(posedge clk) rst |=> irq_n);

  p_fields_r5: assert property (@(posedge clk) disable iff (rst)
    (status_out[5:0] == 6'b0) && (status_out[7] == timer_flag_in));

  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (status_rd && !edge_hit) |=> !status_out[6]);

  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !status_rd) |=> flag_q);

  p_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (status_rd && edge_hit) |=> status_out[6]);

  p_irq_off_r8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !ctrl_addr[1]) |=> irq_n);

  p_irq_on_r8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && ctrl_addr[1] && status_out[6] && !status_rd) |=> !irq_n);
endmodule

bind port_edge_flag port_edge_flag_chk u_chk (
  .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_addr(ctrl_addr),
  .status_rd(status_rd), .timer_flag_in(timer_flag_in),
  .status_out(status_out), .irq_n(irq_n),
  .edge_hit(edge_hit), .flag_q(flag_q)
);

// File: tb/port_edge_flag_tb.sv
`timescale 1ns/1ps
module port_edge_flag_tb;
  localparam int N = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin_async = 1'b0;
  logic       ctrl_wr = 1'b0;
  logic [1:0] ctrl_addr = 2'b00;
  logic       status_rd = 1'b0;
  logic       timer_flag_in = 1'b0;
  logic [7:0] st_a, st_b;
  logic       irq_a, irq_b;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  port_edge_flag u_dut (
    .clk(clk), .rst(rst), .pin_async(pin_async), .ctrl_wr(ctrl_wr),
    .ctrl_addr(ctrl_addr), .status_rd(status_rd), .timer_flag_in(timer_flag_in),
    .status_out(st_a), .irq_n(irq_a));

  port_edge_flag #(.SYNC_STAGES(3), .FLAG_INIT(1'b1)) u_pre (
    .clk(clk), .rst(rst), .pin_async(pin_async), .ctrl_wr(ctrl_wr),
    .ctrl_addr(ctrl_addr), .status_rd(status_rd), .timer_flag_in(timer_flag_in),
    .status_out(st_b), .irq_n(irq_b));

  function automatic logic [7:0] exp_status(input logic tf, input logic fl);
    return {tf, fl, 6'b0};
  endfunction

  function automatic logic exp_flag(input logic from_v, input logic to_v, input logic rise);
    return (from_v != to_v) && (to_v == rise);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic ctrl(input logic [1:0] a);
    ctrl_addr = a; ctrl_wr = 1'b1; tick(); ctrl_wr = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    status_rd = 1'b1; v = st_a; tick(); status_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic cur;
    void'($urandom(32'h1357));
    repeat (3) tick();
    rst = 1'b0;
    tick();
    check("R1 flag", st_a, 8'h00);
    check("R1 irq", irq_a, 1);
    check("R10 preset flag", st_b, 8'h40);
    check("R10 preset irq", irq_b, 1);

    timer_flag_in = 1'b1; tick();
    check("R5 timer bit", st_a, exp_status(1'b1, 1'b0));
    check("R5 preset fields", st_b, exp_status(1'b1, 1'b1));
    timer_flag_in = 1'b0;

    ctrl(2'b10); tick();
    check("R8 preset irq", irq_b, 0);
    check("R8 flag0 irq", irq_a, 1);
    rd(v);
    check("R10 read cleared", st_b[6], 0);
    check("R8 irq after clear", irq_b, 1);
    ctrl(2'b00);

    pin_async = 1'b1; repeat (6) tick();
    check("R2 rise ignored", st_a[6], 0);
    pin_async = 1'b0; repeat (6) tick();
    check("R2 fall sets", st_a[6], 1);
    check("R8 disabled irq", irq_a, 1);
    rd(v);
    check("R6 read value", v[6], 1);
    check("R6 cleared", st_a[6], 0);
    repeat (10) tick();
    check("R4 held level", st_a[6], 0);

    ctrl(2'b01);
    pin_async = 1'b1; repeat (6) tick();
    check("R3 rise sets", st_a[6], 1);
    rd(v);
    pin_async = 1'b0; repeat (6) tick();
    check("R3 fall ignored", st_a[6], 0);

    pin_async = 1'b1;
    repeat (N) tick();
    check("R9 not early", st_a[6], 0);
    tick();
    check("R9 on time", st_a[6], 1);

    rd(v);
    pin_async = 1'b0; repeat (6) tick();
    pin_async = 1'b1;
    repeat (N) tick();
    rd(v);
    check("R7 read before edge", v[6], 0);
    check("R7 edge kept", st_a[6], 1);

    ctrl(2'b11); tick();
    check("R8 enable asserts", irq_a, 0);
    ctrl(2'b01);
    check("R8 disable releases", irq_a, 1);
    check("R6 write keeps flag", st_a[6], 1);
    ctrl(2'b11);
    rd(v);
    check("R8 read releases", irq_a, 1);

    cur = pin_async;
    for (int i = 0; i < 40; i++) begin
      logic pol, en, nv, tf, ef;
      pol = 1'($urandom % 2);
      en  = 1'($urandom % 2);
      nv  = 1'($urandom % 2);
      tf  = 1'($urandom % 2);
      ctrl({en, pol});
      rd(v);
      timer_flag_in = tf;
      pin_async = nv;
      repeat (6) tick();
      ef = exp_flag(cur, nv, pol);
      check(pol ? "R3 random" : "R2 random", st_a, exp_status(tf, ef));
      check("R8 random", irq_a, !(ef && en));
      cur = nv;
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule